// File: doc/BRIEF.md
# Lane-Partitioned SIMD Integer Unit

This block is a 128-bit vector integer datapath with one registered stage. It takes two source vectors (N and M), the old value of the destination (D), a 32-bit scalar, an operation code and a lane-size code. It splits the vectors into sixteen 8-bit, eight 16-bit or four 32-bit lanes. It can add or subtract lane by lane, build bit-test and equality masks per lane, do a bitwise select over the whole vector, invert a whole vector, or broadcast the scalar into every lane.

The lane size is chosen on each request. The adder cuts its carry chain at the boundaries of the selected lanes. Mask results fill each lane entirely with ones or entirely with zeros. The result and a valid pulse appear one clock after a valid request. The result register keeps its value between requests.

Top module: `simd_lane_unit`

## Requirements
- R1: Lane size code 0 selects 16 lanes of 8 bits, code 1 selects 8 lanes of 16 bits, and code 2 selects 4 lanes of 32 bits. Lane 0 occupies the least significant bits of every vector.
- R2: Op code 0 (add) gives N+M in each lane, modulo the lane width. No carry passes into the next lane.
- R3: Op code 1 (subtract) gives N-M in each lane, modulo the lane width. No borrow passes into the next lane.
- R4: Op code 2 (bit test) sets every bit of a lane to 1 when (N AND M) is nonzero in that lane, and clears the lane otherwise.
- R5: Op code 3 (equal) sets every bit of a lane to 1 when the N lane equals the M lane, and clears the lane otherwise.
- R6: Op code 4 (select) gives (D AND N) OR (NOT D AND M) over all 128 bits.
- R7: Op code 5 (invert) gives NOT M over all 128 bits, whatever the lane size code (0 to 2).
- R8: Op code 6 (broadcast) keeps the low 8, 16 or 32 bits of the scalar, as the lane size selects, and copies them into every lane.
- R9: Lane size code 3 is reserved. With any op code, the result is N unchanged and `illegal` is high for exactly the one cycle in which `out_valid` is high.
- R10: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high. Without a valid request, `result` keeps its previous value.
- R11: Synchronous active-high `rst` clears `result`, `out_valid` and `illegal`.
- R12: Op code 7 gives N unchanged and does not raise `illegal` for lane size codes 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| op | input | 3 | Operation code (see R2 to R12) |
| lane_size | input | 2 | Lane size code (see R1, R9) |
| opnd_n | input | 128 | Source vector N |
| opnd_m | input | 128 | Source vector M |
| dest_old | input | 128 | Old destination value D, used as the select mask |
| scalar | input | 32 | Scalar for broadcast |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 128 | Registered result vector |
| illegal | output | 1 | Reserved lane size seen |

## Verification
The bench adds all-ones vectors to ones placed at each lane's low end, and subtracts from zero. A design that let the carry or borrow cross a lane boundary would then leave nonzero bytes, or wrong high bytes, at the edges of the lanes. The equality and bit-test cases use the same operands at two lane sizes, with lanes that differ in only one byte. A mask logic that merged bytes into the wrong lanes would then give partial masks. Broadcast is checked at every size, to catch scalar bits that leak above the lane width. The reserved size is applied with the invert op, to show that the size check takes precedence, and the bench confirms that `illegal` falls after one cycle and that the result holds when no request arrives.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;
   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_TST  = 3'd2,
      OP_CEQ  = 3'd3,
      OP_BSL  = 3'd4,
      OP_NOT  = 3'd5,
      OP_DUP  = 3'd6,
      OP_PASS = 3'd7
   } simd_op_e;

   typedef enum logic [1:0] {
      LS_B8  = 2'd0,
      LS_H16 = 2'd1,
      LS_W32 = 2'd2,
      LS_RSV = 2'd3
   } lane_size_e;
endpackage

// File: rtl/lane_addsub.sv
module lane_addsub
   import simd_lane_pkg::*;
#(
   parameter int VW = 128
) (
   input  logic [VW-1:0] a,
   input  logic [VW-1:0] b,
   input  logic          sub,
   input  lane_size_e    size,
   output logic [VW-1:0] sum
);
   localparam int NB = VW / 8;

   logic [NB-1:0] co;
   logic [VW-1:0] bx;

   assign bx = b ^ {VW{sub}};

   generate
      for (genvar i = 0; i < NB; i++) begin : g_byte
         localparam bit AT2 = (i % 2) == 0;
         localparam bit AT4 = (i % 4) == 0;
         logic lane_start;
         logic cin;
         assign lane_start = (size == LS_B8) || ((size == LS_H16) && AT2) || AT4;
         if (i == 0) begin : g_first
            assign cin = sub;
         end else begin : g_rest
            assign cin = lane_start ? sub : co[i-1];
         end
         if (i == NB - 1) begin : g_top
            assign sum[8*i +: 8] = a[8*i +: 8] + bx[8*i +: 8] + {7'd0, cin};
            assign co[i] = 1'b0;
         end else begin : g_mid
            logic [8:0] s9;
            assign s9 = {1'b0, a[8*i +: 8]} + {1'b0, bx[8*i +: 8]} + {8'd0, cin};
            assign sum[8*i +: 8] = s9[7:0];
            assign co[i] = s9[8];
         end
      end
   endgenerate
endmodule

// File: rtl/lane_mask.sv
module lane_mask
   import simd_lane_pkg::*;
#(
   parameter int VW = 128
) (
   input  logic [VW-1:0] a,
   input  logic [VW-1:0] b,
   input  logic          is_eq,
   input  lane_size_e    size,
   output logic [VW-1:0] mask
);
   localparam int NB = VW / 8;

   logic [NB-1:0] hit;

   generate
      for (genvar i = 0; i < NB; i++) begin : g_flag
         assign hit[i] = is_eq ? (a[8*i +: 8] == b[8*i +: 8])
                               : (|(a[8*i +: 8] & b[8*i +: 8]));
      end
      for (genvar i = 0; i < NB; i++) begin : g_lane
         localparam int P = i - (i % 2);
         localparam int Q = i - (i % 4);
         logic pair_hit, quad_hit, sel;
         assign pair_hit = is_eq ? (&hit[P +: 2]) : (|hit[P +: 2]);
         assign quad_hit = is_eq ? (&hit[Q +: 4]) : (|hit[Q +: 4]);
         always_comb begin
            case (size)
               LS_B8:   sel = hit[i];
               LS_H16:  sel = pair_hit;
               default: sel = quad_hit;
            endcase
         end
         assign mask[8*i +: 8] = {8{sel}};
      end
   endgenerate
endmodule

// File: rtl/lane_bcast.sv
module lane_bcast
   import simd_lane_pkg::*;
#(
   parameter int VW = 128
) (
   input  logic [31:0]   scalar,
   input  lane_size_e    size,
   output logic [VW-1:0] vec
);
   localparam int NW = VW / 32;

   logic [31:0] word;

   always_comb begin
      case (size)
         LS_B8:   word = {4{scalar[7:0]}};
         LS_H16:  word = {2{scalar[15:0]}};
         default: word = scalar;
      endcase
   end

   generate
      for (genvar w = 0; w < NW; w++) begin : g_word
         assign vec[32*w +: 32] = word;
      end
   endgenerate
endmodule

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
   import simd_lane_pkg::*;
#(
   parameter int VW = 128
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [2:0]    op,
   input  logic [1:0]    lane_size,
   input  logic [VW-1:0] opnd_n,
   input  logic [VW-1:0] opnd_m,
   input  logic [VW-1:0] dest_old,
   input  logic [31:0]   scalar,
   output logic          out_valid,
   output logic [VW-1:0] result,
   output logic          illegal
);
   generate
      if ((VW % 32) != 0 || VW < 32) begin : g_bad_width
         $error("simd_lane_unit: VW must be a nonzero multiple of 32");
      end
   endgenerate

   simd_op_e   op_e;
   lane_size_e sz;
   logic [VW-1:0] arith, tmask, bcast, nxt;
   logic          rsv;

   assign op_e = simd_op_e'(op);
   assign sz   = lane_size_e'(lane_size);
   assign rsv  = (sz == LS_RSV);

   lane_addsub #(.VW(VW)) i_addsub (
      .a(opnd_n), .b(opnd_m), .sub(op_e == OP_SUB), .size(sz), .sum(arith)
   );

   lane_mask #(.VW(VW)) i_mask (
      .a(opnd_n), .b(opnd_m), .is_eq(op_e == OP_CEQ), .size(sz), .mask(tmask)
   );

   lane_bcast #(.VW(VW)) i_bcast (
      .scalar(scalar), .size(sz), .vec(bcast)
   );

   always_comb begin
      if (rsv) begin
         nxt = opnd_n;
      end else begin
         case (op_e)
            OP_ADD, OP_SUB: nxt = arith;
            OP_TST, OP_CEQ: nxt = tmask;
            OP_BSL:         nxt = (dest_old & opnd_n) | (~dest_old & opnd_m);
            OP_NOT:         nxt = ~opnd_m;
            OP_DUP:         nxt = bcast;
            default:        nxt = opnd_n;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         result    <= '0;
         out_valid <= 1'b0;
         illegal   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         illegal   <= in_valid && rsv;
         if (in_valid) result <= nxt;
      end
   end

   // R10
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(result)));
   // R9
   rsv_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && lane_size == 2'd3) |=> (illegal && result == $past(opnd_n)));
   // R9
   illegal_only_valid_chk: assert property (@(posedge clk) disable iff (rst)
      illegal |-> out_valid);
   // R2
   low_byte_add_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op == 3'd0 && lane_size != 2'd3) |=>
      (result[7:0] == $past(opnd_n[7:0]) + $past(opnd_m[7:0])));
   // R7
   invert_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op == 3'd5 && lane_size != 2'd3) |=> (result == ~$past(opnd_m)));
endmodule

// File: tb/test_simd_lane_unit.sv
`timescale 1ns/1ps
module test_simd_lane_unit;
   typedef struct packed {
      logic [23:0]  tag;
      logic [2:0]   op;
      logic [1:0]   sz;
      logic [127:0] n;
      logic [127:0] m;
      logic [127:0] d;
      logic [31:0]  s;
   } vec_t;

   localparam logic [127:0] ALL1 = {128{1'b1}};
   localparam logic [127:0] ONE8 = {16{8'h01}};
   localparam logic [127:0] ONE16 = {8{16'h0001}};
   localparam logic [127:0] ONE32 = {4{32'h00000001}};
   localparam logic [127:0] PA = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
   localparam logic [127:0] PB = 128'h1111_2222_F0F0_0F0F_8000_7FFF_FFFF_0001;
   localparam logic [127:0] EA = 128'h1234_5678_9ABC_DEF0_1111_2222_3333_4444;
   localparam logic [127:0] EB = 128'h1234_0000_9ABC_DEF1_1111_2223_3333_4444;
   localparam logic [127:0] TA = 128'h00FF_0F00_0000_0001_8000_0000_0000_00F0;
   localparam logic [127:0] TB = 128'h0F00_0F00_FFFF_FFFE_8000_0000_FFFF_000F;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{"R2 ", 3'd0, 2'd0, ALL1, ONE8,  '0, 32'h0},
      '{"R2 ", 3'd0, 2'd1, ALL1, ONE16, '0, 32'h0},
      '{"R2 ", 3'd0, 2'd2, ALL1, ONE32, '0, 32'h0},
      '{"R2 ", 3'd0, 2'd1, PA,   PB,    '0, 32'h0},
      '{"R3 ", 3'd1, 2'd0, '0,   ONE8,  '0, 32'h0},
      '{"R3 ", 3'd1, 2'd2, '0,   ONE32, '0, 32'h0},
      '{"R3 ", 3'd1, 2'd1, PA,   PB,    '0, 32'h0},
      '{"R4 ", 3'd2, 2'd0, TA,   TB,    '0, 32'h0},
      '{"R4 ", 3'd2, 2'd2, TA,   TB,    '0, 32'h0},
      '{"R5 ", 3'd3, 2'd1, EA,   EB,    '0, 32'h0},
      '{"R5 ", 3'd3, 2'd0, EA,   EB,    '0, 32'h0},
      '{"R5 ", 3'd3, 2'd2, EA,   EB,    '0, 32'h0},
      '{"R6 ", 3'd4, 2'd1, {8{16'hAAAA}}, {8{16'h5555}}, {8{16'hFF00}}, 32'h0},
      '{"R7 ", 3'd5, 2'd0, PB,   PA,    '0, 32'h0},
      '{"R7 ", 3'd5, 2'd2, PB,   PA,    '0, 32'h0},
      '{"R8 ", 3'd6, 2'd0, '0,   '0,    '0, 32'h12345678},
      '{"R8 ", 3'd6, 2'd1, '0,   '0,    '0, 32'h12345678},
      '{"R8 ", 3'd6, 2'd2, '0,   '0,    '0, 32'h12345678},
      '{"R9 ", 3'd5, 2'd3, PA,   PB,    '0, 32'h0},
      '{"R12", 3'd7, 2'd1, PB,   PA,    '0, 32'h0}
   };

   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [2:0]   op;
   logic [1:0]   lane_size;
   logic [127:0] opnd_n, opnd_m, dest_old;
   logic [31:0]  scalar;
   logic         out_valid, illegal;
   logic [127:0] result;
   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   simd_lane_unit i_simd_lane_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lane_size(lane_size),
      .opnd_n(opnd_n), .opnd_m(opnd_m), .dest_old(dest_old), .scalar(scalar),
      .out_valid(out_valid), .result(result), .illegal(illegal)
   );

   function automatic logic [128:0] model(input logic [2:0] o, input logic [1:0] z,
         input logic [127:0] n, input logic [127:0] m, input logic [127:0] d,
         input logic [31:0] s);
      logic [127:0] res;
      int w;
      logic [31:0] mk;
      res = '0;
      if (z == 2'd3) return {1'b1, n};
      if (o == 3'd4) return {1'b0, (d & n) | (~d & m)};
      if (o == 3'd5) return {1'b0, ~m};
      if (o == 3'd7) return {1'b0, n};
      w = 8 << z;
      mk = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
      for (int l = 0; l < 128 / w; l++) begin
         logic [31:0] a, b, r;
         a = 32'(n >> (l * w)) & mk;
         b = 32'(m >> (l * w)) & mk;
         case (o)
            3'd0: r = a + b;
            3'd1: r = a - b;
            3'd2: r = ((a & b) != 0) ? mk : 32'h0;
            3'd3: r = (a == b) ? mk : 32'h0;
            default: r = s;
         endcase
         res = res | ({96'h0, r & mk} << (l * w));
      end
      return {1'b0, res};
   endfunction

   task automatic check(input string req, input string what,
         input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] o, input logic [1:0] z, input logic [127:0] n,
         input logic [127:0] m, input logic [127:0] d, input logic [31:0] s);
      @(negedge clk);
      op = o; lane_size = z; opnd_n = n; opnd_m = m; dest_old = d; scalar = s;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; in_valid = 1'b0; op = '0; lane_size = '0;
      opnd_n = '0; opnd_m = '0; dest_old = '0; scalar = '0;
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11", "result after reset", result, '0);
      check("R11", "out_valid after reset", {127'h0, out_valid}, '0);
      check("R11", "illegal after reset", {127'h0, illegal}, '0);
      rst = 1'b0;

      for (int k = 0; k < NV; k++) begin
         logic [128:0] e;
         e = model(VECS[k].op, VECS[k].sz, VECS[k].n, VECS[k].m, VECS[k].d, VECS[k].s);
         issue(VECS[k].op, VECS[k].sz, VECS[k].n, VECS[k].m, VECS[k].d, VECS[k].s);
         check(string'(VECS[k].tag), "result", result, e[127:0]);
         check("R10", "out_valid pulse", {127'h0, out_valid}, 128'h1);
         check("R9", "illegal flag", {127'h0, illegal}, {127'h0, e[128]});
      end

      // R2 carry cut at lane boundaries, hand value
      issue(3'd0, 2'd0, ALL1, ONE8, '0, 32'h0);
      check("R2", "byte lanes wrap", result, '0);
      // R8 broadcast byte, hand value
      issue(3'd6, 2'd0, '0, '0, '0, 32'hCAFE_BE5A);
      check("R8", "byte broadcast", result, {16{8'h5A}});
      // R1 lane 0 in low bits
      issue(3'd0, 2'd2, '0, 128'h00000004_00000003_00000002_00000001, '0, 32'h0);
      check("R1", "lane 0 low word", {96'h0, result[31:0]}, 128'h1);
      check("R1", "lane 3 high word", {96'h0, result[127:96]}, 128'h4);

      // R9 illegal lasts one cycle; R10 result holds when idle
      issue(3'd0, 2'd3, PB, PA, '0, 32'h0);
      check("R9", "reserved passes N", result, PB);
      @(negedge clk);
      check("R9", "illegal drops", {127'h0, illegal}, '0);
      check("R10", "valid drops", {127'h0, out_valid}, '0);
      opnd_n = PA; op = 3'd5;
      @(negedge clk);
      check("R10", "result held while idle", result, PB);

      // R11 reset in the middle clears outputs
      issue(3'd5, 2'd0, '0, '0, '0, 32'h0);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R11", "result cleared mid-run", result, '0);
      check("R11", "valid cleared mid-run", {127'h0, out_valid}, '0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule